// File: doc/BRIEF.md
# Character Display Port

This block is a bus slave that lets a processor send characters to a display one at a time. It decodes two word addresses on a 16-bit memory-mapped bus. The status word at 0xFE04 reports whether the display can take another character, and it holds an interrupt-enable bit that software sets or clears. The data word at 0xFE06 accepts the next character and returns the last one that was accepted.

A data write made while the port is ready latches the low byte. It sends that byte to the display sink as a one-cycle start pulse and marks the port busy. The port stays busy until the sink returns a one-cycle done pulse. Data writes made while busy are dropped without any trace. The interrupt line is high whenever the port is ready and interrupts are enabled. Software can therefore either poll the ready bit or wait for the interrupt.

Bus reads are combinational from the registered state, so read data is valid in the same cycle as the request. Writes take effect at the clock edge that samples them.

Top module: `char_display_port`

## Requirements
- R1: After reset the port is ready, the interrupt enable is 0, `irq` and `disp_start` are low, and the data word reads as 0.
- R2: A read at 0xFE04 returns the ready flag in bit 15 and the interrupt enable in bit 14. Every other bit reads 0.
- R3: A write at 0xFE06 while ready clears the ready flag. In the next cycle `disp_start` is high for exactly one cycle, and `disp_char` carries the written bits [7:0].
- R4: A write at 0xFE06 while not ready produces no start pulse. It changes neither the stored character nor the ready flag.
- R5: A `disp_done` pulse while busy sets the ready flag at that edge. A `disp_done` pulse while ready has no effect.
- R6: A write at 0xFE04 sets the interrupt enable from bit 14. The other written bits, including bit 15, do not change the port state.
- R7: `irq` is high exactly when the ready flag and the interrupt enable are both 1.
- R8: A read at 0xFE06 returns the last accepted character in bits [7:0], with bits [15:8] at 0.
- R9: A write to any other address changes nothing, and a read from any other address returns 0.
- R10: A bus cycle with `bus_sel` low has no effect and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle |
| disp_start | output | 1 | One-cycle pulse: new character for the sink |
| disp_char | output | 8 | Character presented with the start pulse |
| disp_done | input | 1 | One-cycle pulse: sink finished the character |
| irq | output | 1 | Interrupt request |

## Verification
A ready flag stuck busy shows up as bit 15 low on the next status read. It also silences every later data write, so the missing start pulse is visible within one cycle of the first attempted write. A ready flag stuck ready lets a second write through. That write produces an extra start pulse and changes the character read back in the following cycle. A wrong interrupt-enable value, or a wrong combination of it with the ready flag, is visible on `irq` and on status bit 14 in the cycle right after the status write or done pulse that should have changed it. Random traffic mixes writes that race busy periods with done pulses sent at unexpected times, so a flag with the wrong value is caught within a few operations.

// File: rtl/char_display_port_pkg.sv
package char_display_port_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_STAT_WR,
        ACC_STAT_RD,
        ACC_DATA_WR,
        ACC_DATA_RD,
        ACC_OTHER
    } access_e;

endpackage

// File: rtl/char_display_port_decode.sv
module char_display_port_decode
    import char_display_port_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] STAT_ADDR = 16'hFE04,
    parameter logic [15:0] DATA_ADDR = 16'hFE06
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output access_e           kind
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

    always_comb begin
        kind = ACC_NONE;
        if (sel) begin
            if (addr == STAT_A) begin
                kind = we ? ACC_STAT_WR : ACC_STAT_RD;
            end else if (addr == DATA_A) begin
                kind = we ? ACC_DATA_WR : ACC_DATA_RD;
            end else begin
                kind = ACC_OTHER;
            end
        end
    end
endmodule

// File: rtl/char_display_port_core.sv
module char_display_port_core
    import char_display_port_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  access_e           kind,
    input  logic              wr_ie,
    input  logic [CHAR_W-1:0] wr_chr,
    input  logic              done,
    output logic              rdy,
    output logic              ie,
    output logic [CHAR_W-1:0] chr,
    output logic              start
);
    typedef struct packed {
        logic              rdy;
        logic              ie;
        logic [CHAR_W-1:0] chr;
        logic              start;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        case (kind)
            ACC_DATA_WR: begin
                if (st_q.rdy) begin
                    st_d.chr   = wr_chr;
                    st_d.rdy   = 1'b0;
                    st_d.start = 1'b1;
                end
            end
            ACC_STAT_WR: st_d.ie = wr_ie;
            default: ;
        endcase
        if (done && !st_q.rdy) begin
            st_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rdy   <= 1'b1;
            st_q.ie    <= 1'b0;
            st_q.chr   <= '0;
            st_q.start <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy   = st_q.rdy;
    assign ie    = st_q.ie;
    assign chr   = st_q.chr;
    assign start = st_q.start;
endmodule

// File: rtl/char_display_port_rdmux.sv
module char_display_port_rdmux
    import char_display_port_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int CHAR_W  = 8,
    parameter int RDY_BIT = 15,
    parameter int IE_BIT  = 14
) (
    input  access_e           kind,
    input  logic              rdy,
    input  logic              ie,
    input  logic [CHAR_W-1:0] chr,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (kind)
            ACC_STAT_RD: begin
                rdata[RDY_BIT] = rdy;
                rdata[IE_BIT]  = ie;
            end
            ACC_DATA_RD: rdata[CHAR_W-1:0] = chr;
            default: ;
        endcase
    end
endmodule

// File: rtl/char_display_port.sv
module char_display_port
    import char_display_port_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 16,
    parameter int          CHAR_W    = 8,
    parameter int          RDY_BIT   = 15,
    parameter int          IE_BIT    = 14,
    parameter logic [15:0] STAT_ADDR = 16'hFE04,
    parameter logic [15:0] DATA_ADDR = 16'hFE06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              disp_start,
    output logic [CHAR_W-1:0] disp_char,
    input  logic              disp_done,
    output logic              irq
);
    access_e           kind;
    logic              rdy_w;
    logic              ie_w;
    logic [CHAR_W-1:0] chr_w;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata;

    char_display_port_decode #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
    ) dec_i (
        .sel(bus_sel), .we(bus_we), .addr(bus_addr), .kind(kind)
    );

    char_display_port_core #(.CHAR_W(CHAR_W)) core_i (
        .clk(clk), .rst_n(rst_n), .kind(kind),
        .wr_ie(bus_wdata[IE_BIT]), .wr_chr(bus_wdata[CHAR_W-1:0]),
        .done(disp_done), .rdy(rdy_w), .ie(ie_w), .chr(chr_w),
        .start(disp_start)
    );

    char_display_port_rdmux #(
        .DATA_W(DATA_W), .CHAR_W(CHAR_W), .RDY_BIT(RDY_BIT), .IE_BIT(IE_BIT)
    ) rd_i (
        .kind(kind), .rdy(rdy_w), .ie(ie_w), .chr(chr_w), .rdata(bus_rdata)
    );

    assign disp_char = chr_w;
    assign irq       = rdy_w & ie_w;
endmodule

// File: rtl/char_display_port_chk.sv
module char_display_port_chk #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 16,
    parameter int          CHAR_W    = 8,
    parameter int          IE_BIT    = 14,
    parameter logic [15:0] STAT_ADDR = 16'hFE04,
    parameter logic [15:0] DATA_ADDR = 16'hFE06
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              disp_done,
    input logic              disp_start,
    input logic [CHAR_W-1:0] disp_char,
    input logic              irq,
    input logic              rdy
);
    logic data_wr, stat_wr;
    assign data_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(DATA_ADDR));
    assign stat_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(STAT_ADDR));

    // R3
    p_accept_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && rdy) |=> (disp_start && !rdy && disp_char == $past(bus_wdata[CHAR_W-1:0])));

    // R3
    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_start |=> !disp_start);

    // R4
    p_busy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !rdy) |=> (!disp_start && $stable(disp_char)));

    // R5
    p_done_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_done && !rdy) |=> rdy);

    // R6 / R7
    p_ie_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !bus_wdata[IE_BIT]) |=> !irq);

    // R10
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel && !disp_done) |=> ($stable(rdy) && $stable(disp_char) && !disp_start));
endmodule

bind char_display_port char_display_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .IE_BIT(IE_BIT),
    .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .disp_done(disp_done),
    .disp_start(disp_start), .disp_char(disp_char), .irq(irq), .rdy(rdy_w)
);

// File: tb/char_display_port_tb.sv
module char_display_port_tb_top;
    localparam logic [15:0] STAT_A = 16'hFE04;
    localparam logic [15:0] DATA_A = 16'hFE06;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0, disp_done = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic        disp_start, irq;
    logic [7:0]  disp_char;

    int checks = 0, errors = 0;
    bit m_rdy, m_ie;
    logic [7:0] m_chr;

    always #2.5 clk = ~clk;

    char_display_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .disp_start(disp_start), .disp_char(disp_char),
        .disp_done(disp_done), .irq(irq)
    );

    function automatic logic [15:0] exp_read(bit sel, bit we, logic [15:0] a);
        if (!sel || we) return 16'h0;
        if (a == STAT_A) return {m_rdy, m_ie, 14'h0};
        if (a == DATA_A) return {8'h00, m_chr};
        return 16'h0;
    endfunction

    task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(bit sel, bit we, logic [15:0] a, logic [15:0] w, bit done, string req);
        logic [15:0] er;
        bit acc;
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = w; disp_done = done;
        #1;
        er = exp_read(sel, we, a);
        check(bus_rdata == er, req, bus_rdata, er);
        acc = sel && we && a == DATA_A && m_rdy;
        if (sel && we && a == STAT_A) m_ie = w[14];
        if (done && !m_rdy) m_rdy = 1'b1;
        if (acc) begin m_chr = w[7:0]; m_rdy = 1'b0; end
        @(posedge clk); #1;
        check(disp_start == acc, acc ? "R3 start" : "R4 no start", 16'(disp_start), 16'(acc));
        check(disp_char == m_chr, "R3/R4/R8 char", 16'(disp_char), 16'(m_chr));
        check(irq == (m_rdy && m_ie), "R7 irq", 16'(irq), 16'(m_rdy && m_ie));
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; disp_done = 1'b0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        m_rdy = 1'b1; m_ie = 1'b0; m_chr = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        check(irq == 0 && disp_start == 0, "R1 reset outputs", {irq, disp_start}, 0);
        cyc(1, 0, STAT_A, 0, 0, "R1/R2 status after reset");
        cyc(1, 0, DATA_A, 0, 0, "R1/R8 data after reset");
        // R3 accept, R4 drop while busy
        cyc(1, 1, DATA_A, 16'hBE41, 0, "R3 write");
        cyc(1, 0, STAT_A, 0, 0, "R2 busy status");
        cyc(1, 1, DATA_A, 16'h0042, 0, "R4 busy write");
        cyc(1, 0, DATA_A, 0, 0, "R4/R8 char kept");
        // R5 done while busy, then while ready
        cyc(0, 0, 0, 0, 1, "R5 done busy");
        cyc(0, 0, 0, 0, 1, "R5 done ready");
        cyc(1, 0, STAT_A, 0, 0, "R5 ready again");
        // R6 status write, bit 15 ignored
        cyc(1, 1, STAT_A, 16'h4000, 0, "R6 ie set");
        cyc(1, 1, DATA_A, 16'h0043, 0, "R7 irq drops");
        cyc(1, 1, STAT_A, 16'hBFFF, 0, "R6 ie clear other bits");
        cyc(1, 0, STAT_A, 0, 0, "R6 readback");
        // R9 other addresses, R10 sel low
        cyc(1, 1, 16'hFE05, 16'h4000, 1, "R9 other write");
        cyc(1, 0, 16'hFE00, 0, 0, "R9 other read");
        cyc(0, 1, DATA_A, 16'h0055, 0, "R10 sel low write");
        cyc(0, 0, STAT_A, 0, 0, "R10 sel low read");
        cyc(1, 1, STAT_A, 16'h4000, 0, "R6 ie set again");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 7);
            logic [15:0] w = 16'($urandom);
            bit d = ($urandom_range(0, 3) == 0);
            case (op)
                0, 1: cyc(1, 1, DATA_A, w, d, "R3/R4 random data write");
                2:    cyc(1, 1, STAT_A, w, d, "R6 random status write");
                3:    cyc(1, 0, STAT_A, w, d, "R2 random status read");
                4:    cyc(1, 0, DATA_A, w, d, "R8 random data read");
                5:    cyc(1, $urandom_range(0, 1), 16'($urandom) | 16'h0001, w, d, "R9 random other");
                default: cyc(0, $urandom_range(0, 1), DATA_A, w, d, "R10/R5 random idle");
            endcase
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule